// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host sends single-beat read or write requests over a valid/ready handshake. The controller turns each request into the strobe sequence the RAM needs, and it counts every window in whole clock cycles. The RAM is selected through two chip enables of opposite polarity. A write is controlled by the write-enable strobe. A read is controlled by the output-enable strobe.

Requests carry no data burst and need no arbitration. A request is taken only when `req_ready` is high, in the same cycle that `req_valid` is high. The host may hold `req_valid` high at any time. While the controller is busy, nothing on the request inputs is sampled. Read data comes back as a one-cycle `rsp_valid` strobe with no back-pressure, so the host must take the data in that cycle. The `rsp_rdata` value then stays unchanged until the next read completes.

Top module: `asram_ctl`

## Requirements
- R1: While `rst` is high and after its last clock edge, the controller drives `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0, with `req_ready`=1 and `rsp_valid`=0.
- R2: In every cycle where `req_ready` is high, the RAM is deselected, its output is disabled, no write strobe is active and the data bus is released. These are the same pin levels as in R1.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` goes low in the next cycle. It stays low for RD_CYC cycles after a read. After a write it stays low for WE_CYC cycles, or for WE_CYC+1 cycles when R8 applies.
- R4: For the RD_CYC cycles after a read is accepted, the controller drives `mem_addr` with the request address, `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0.
- R5: `rsp_valid` is high for exactly one cycle, RD_CYC+1 cycles after the read is accepted. In that cycle `rsp_rdata` holds the value that `mem_dq_in` had on the clock edge ending the last read cycle. `req_ready` is high in that same cycle.
- R6: For the WE_CYC cycles of a write pulse, the controller drives `mem_we_n`=0, `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=1 and `mem_dq_oe`=1. Throughout the pulse, `mem_addr` and `mem_dq_out` stay fixed at the request address and data.
- R7: A write ends on a single edge. On that edge, `mem_we_n` rises, both chip enables deselect and `mem_dq_oe` drops. The next cycle is idle.
- R8: A write whose previous access was a read first spends one turnaround cycle with every pin at its R2 level. A write after a write, or the first access after reset, has no turnaround cycle.
- R9: Outside the capture edge of R5, changes on `mem_dq_in` have no effect on `rsp_rdata`.
- R10: While `req_ready` is low, the request inputs are ignored. `mem_addr` keeps the accepted address, and no extra access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_ce | output | 1 | RAM chip enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned from the RAM |

## Verification
The RAM pins change one cycle after the accepting edge. They hold the read pattern for cycles 1 to RD_CYC, or the write pattern for cycles 1 to WE_CYC (shifted by one cycle when a turnaround is inserted). `rsp_valid` and `rsp_rdata` are due in cycle RD_CYC+1. The bench model pushes one expected entry per future cycle when it sees an acceptance, and pops and compares one entry on every falling edge. This places each comparison in the exact cycle a result is due. During busy cycles the bench drives junk requests, and it changes `mem_dq_in` in every cycle outside a read. Together these test the ignore rules of R9 and R10.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } st_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pins_t;

  localparam pins_t PINS_OFF = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
  localparam pins_t PINS_RD  = '{ce_n: 1'b0, ce: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
  localparam pins_t PINS_WR  = '{ce_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};

  function automatic pins_t pins_for(st_e s);
    pins_t p;
    case (s)
      ST_RD:   p = PINS_RD;
      ST_WR:   p = PINS_WR;
      default: p = PINS_OFF;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WE_CYC = 2,
  parameter int CW     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output st_e  st_d,
  output logic rd_done
);

  st_e           st_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_rd_q;

  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WE_LAST = CW'(WE_CYC - 1);

  assign ready  = (st_q == ST_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rd_done = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          if (req_write) st_d = last_rd_q ? ST_TURN : ST_WR;
          else           st_d = ST_RD;
        end
      end
      ST_TURN: begin
        cnt_d = '0;
        st_d  = ST_WR;
      end
      ST_WR: begin
        if (cnt_q == WE_LAST) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD: begin
        if (cnt_q == RD_LAST) begin
          st_d    = ST_IDLE;
          cnt_d   = '0;
          rd_done = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (rd_done)           last_rd_q <= 1'b1;
      else if (st_d == ST_WR) last_rd_q <= 1'b0;
    end
  end

endmodule

// File: rtl/asram_pinreg.sv
module asram_pinreg
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  st_e               st_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output pins_t             pins
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pins       <= PINS_OFF;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      pins <= pins_for(st_d);
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 2,
  parameter int WE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CNT_MAX = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int CW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  st_e   st_d;
  logic  accept;
  logic  rd_done;
  pins_t pins;

  asram_fsm #(
    .RD_CYC(RD_CYC),
    .WE_CYC(WE_CYC),
    .CW    (CW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .ready    (req_ready),
    .accept   (accept),
    .st_d     (st_d),
    .rd_done  (rd_done)
  );

  asram_pinreg #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_d      (st_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .pins      (pins)
  );

  asram_rdcap #(
    .DATA_W(DATA_W)
  ) u_rdcap (
    .clk      (clk),
    .rst      (rst),
    .rd_done  (rd_done),
    .dq_in    (mem_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  assign mem_ce_n  = pins.ce_n;
  assign mem_ce    = pins.ce;
  assign mem_oe_n  = pins.oe_n;
  assign mem_we_n  = pins.we_n;
  assign mem_dq_oe = pins.dq_oe;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_read_pins_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n && !mem_dq_oe));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_write_pins_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n && mem_ce));

  assert_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_bus_release_R7: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_oe_n) |-> (mem_we_n && !mem_dq_oe));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctl.sv
module sim_asram_ctl;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RD = 2;
  localparam int WE = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  asram_ctl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WE_CYC(WE)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // pin order: ce_n, ce, oe_n, we_n, dq_oe
  localparam logic [4:0] P_OFF = 5'b10110;
  localparam logic [4:0] P_RD  = 5'b01010;
  localparam logic [4:0] P_WR  = 5'b01101;

  typedef struct {
    bit            busy;
    bit            rsp;
    logic [4:0]    pins;
    bit            chk_addr;
    logic [AW-1:0] addr;
    bit            chk_dout;
    logic [DW-1:0] dout;
    logic [DW-1:0] rdata;
    string         tag;
  } exp_t;

  typedef struct {
    bit            w;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            gap;
  } req_t;

  exp_t          eq[$];
  req_t          rq[$];
  logic [DW-1:0] dev[int];
  logic [DW-1:0] ref_mem[int];

  int n_chk = 0;
  int n_err = 0;

  function automatic logic [DW-1:0] dflt(logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(bit busy, bit rsp, logic [4:0] p, string tag);
    exp_t e;
    e.busy = busy; e.rsp = rsp; e.pins = p; e.tag = tag;
    e.chk_addr = 0; e.addr = '0; e.chk_dout = 0; e.dout = '0; e.rdata = '0;
    return e;
  endfunction

  initial begin
    exp_t       cur;
    exp_t       e;
    req_t       r;
    logic [4:0] act;
    logic [DW-1:0] last_rd;
    bit         have_last;
    bit         last_was_rd;
    int         gap_left;

    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_dq_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    act = {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe};
    check(act == P_OFF, "R1", "reset pins", 32'(act), 32'(P_OFF));
    check(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst = 1'b0;

    rq.push_back('{1, 17'h00010, 8'h3C, 0});
    rq.push_back('{1, 17'h1FFFF, 8'hFF, 0});
    rq.push_back('{0, 17'h00010, 8'h00, 0});
    rq.push_back('{1, 17'h00020, 8'h81, 0});
    rq.push_back('{0, 17'h1FFFF, 8'h00, 2});
    rq.push_back('{0, 17'h00020, 8'h00, 0});
    rq.push_back('{0, 17'h00005, 8'h00, 0});
    rq.push_back('{1, 17'h00000, 8'h00, 3});
    rq.push_back('{0, 17'h00000, 8'h00, 0});
    rq.push_back('{0, 17'h1FFFF, 8'h00, 1});
    rq.push_back('{1, 17'h0ABCD, 8'h5E, 0});
    rq.push_back('{1, 17'h0ABCD, 8'hA1, 0});
    rq.push_back('{0, 17'h0ABCD, 8'h00, 4});

    have_last = 0; last_rd = '0; last_was_rd = 0;
    gap_left = rq[0].gap;

    for (int cyc = 0; cyc < 2000 && (rq.size() > 0 || eq.size() > 0); cyc++) begin
      @(negedge clk);
      if (eq.size() > 0) cur = eq.pop_front();
      else               cur = mk(0, 0, P_OFF, "R2");

      // external RAM model: store while the write strobe overlaps both enables
      if (!mem_we_n && !mem_ce_n && mem_ce && mem_dq_oe) dev[int'(mem_addr)] = mem_dq_out;

      act = {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe};
      check(act == cur.pins, cur.tag, "pins", 32'(act), 32'(cur.pins));
      check(req_ready == !cur.busy, "R3", "ready", 32'(req_ready), 32'(!cur.busy));
      if (cur.chk_addr) check(mem_addr == cur.addr, "R10", "held address", 32'(mem_addr), 32'(cur.addr));
      if (cur.chk_dout) check(mem_dq_out == cur.dout, "R6", "write data", 32'(mem_dq_out), 32'(cur.dout));
      check(rsp_valid == cur.rsp, "R5", "rsp_valid", 32'(rsp_valid), 32'(cur.rsp));
      if (cur.rsp) begin
        check(rsp_rdata == cur.rdata, "R5", "read data", 32'(rsp_rdata), 32'(cur.rdata));
        last_rd = cur.rdata; have_last = 1;
      end else if (have_last) begin
        check(rsp_rdata == last_rd, "R9", "held read data", 32'(rsp_rdata), 32'(last_rd));
      end

      if (!mem_oe_n && !mem_ce_n && mem_ce)
        mem_dq_in = dev.exists(int'(mem_addr)) ? dev[int'(mem_addr)] : dflt(mem_addr);
      else
        mem_dq_in = 8'h5A ^ 8'(cyc);

      if (cur.busy) begin
        // R10 stimulus: junk requests while busy
        req_valid = 1'b1; req_write = cyc[0];
        req_addr = 17'(cyc * 977); req_wdata = 8'(cyc * 13);
      end else if (rq.size() > 0 && gap_left > 0) begin
        req_valid = 1'b0; gap_left--;
      end else if (rq.size() > 0) begin
        r = rq.pop_front();
        gap_left = (rq.size() > 0) ? rq[0].gap : 0;
        req_valid = 1'b1; req_write = r.w; req_addr = r.a; req_wdata = r.d;
        if (r.w) begin
          if (last_was_rd) eq.push_back(mk(1, 0, P_OFF, "R8"));
          for (int i = 0; i < WE; i++) begin
            e = mk(1, 0, P_WR, "R6");
            e.chk_addr = 1; e.addr = r.a; e.chk_dout = 1; e.dout = r.d;
            eq.push_back(e);
          end
          eq.push_back(mk(0, 0, P_OFF, "R7"));
          ref_mem[int'(r.a)] = r.d;
          last_was_rd = 0;
        end else begin
          for (int i = 0; i < RD; i++) begin
            e = mk(1, 0, P_RD, "R4");
            e.chk_addr = 1; e.addr = r.a;
            eq.push_back(e);
          end
          e = mk(0, 1, P_OFF, "R5");
          e.rdata = ref_mem.exists(int'(r.a)) ? ref_mem[int'(r.a)] : dflt(r.a);
          eq.push_back(e);
          last_was_rd = 1;
        end
      end else begin
        req_valid = 1'b0;
      end
    end

    if (rq.size() > 0 || eq.size() > 0) begin
      n_chk++; n_err++;
      $display("FAIL R3 watchdog: actual %0d pending expected 0", rq.size() + eq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule